// File: doc/BRIEF.md
# Sprite Horizontal Position Counter

This block tracks the horizontal position of one movable object, either a player or a missile, in a scanline video generator. A free-running position counter covers the visible part of each line and holds while horizontal blanking is active. The counter issues start events in three cases: when the position strobe restarts it at the current beam position, when it wraps at the end of its span, and when it passes copy offsets chosen by the size code. Each start event travels through a short delay line whose length depends on the object type. At its end the event launches a serial draw window, and `draw_en` stays high for the object's width.

The size code is decoded every pixel clock. A write to it while the object is being drawn therefore stretches or shortens the object in mid-draw. Horizontal blanking discards every pending start and cuts any draw in progress. A copy that would run past the end of the line is therefore never continued on the next line. A strobe that arrives too late in the line to draw produces nothing until the counter next wraps, almost one full sweep later.

The same module serves both object types through parameters. A player uses an 8-pixel base width and a 3-clock start delay. A missile uses a 1-pixel base width and a 2-clock start delay.

Top module: `sprite_hpos`

## Requirements
- R1: After reset, `draw_en` is 0 and stays 0 until a start event has passed through the delay line.
- R2: The position counter advances by one only on clocks with `hblank` low and wraps after LINE_PIX (default 160) visible clocks. Without further strobes, the object therefore repeats every 160 visible clocks.
- R3: A strobe on `pos_reset` in a visible clock t causes the first drawn pixel in visible clock t+START_DELAY. With default parameters this is t+3 for a player and t+2 for a missile. The result is the fourth and third visible pixel for a strobe on the first pixel of a line.
- R4: The drawn width is BASE_W times a scale taken from `size_sel`: code 5 gives ×2, code 7 gives ×4, and every other code gives ×1.
- R5: Extra copies start at counter offsets relative to the main start. Code 1 adds +16. Code 2 adds +32. Code 3 adds +16 and +32. Code 4 adds +64. Code 6 adds +32 and +64. Codes 0, 5 and 7 draw a single copy. The offsets are multiples of COPY_GAP, which defaults to 16.
- R6: The width limit is evaluated against the current `size_sel` on every clock. A change during a draw takes effect at once: the draw ends when its pixel count reaches the new width, or on the current pixel if that count has already been passed.
- R7: A clock with `hblank` high forces `draw_en` low. It also discards any pending start and ends any draw in progress, so no part of a copy is continued after blanking. The next start then comes from a later counter event.
- R8: A strobe during blanking zeroes the counter without issuing a start. The first copy then appears START_DELAY clocks after the counter wraps, 160 visible clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hblank | input | 1 | Horizontal blanking; high freezes the counter and cancels drawing |
| pos_reset | input | 1 | Position strobe: restarts the counter at the current beam position |
| size_sel | input | 3 | Size/copies code, decoded live each clock |
| draw_en | output | 1 | High on pixels where the object's graphics are shown |

## Verification
The hardest situations to reach are those where blanking falls inside the start delay or partway through a draw. The stimulus creates them by raising `hblank` one clock after a strobe, and again three pixels into a player draw. It then runs a whole visible sweep to show that nothing appears until the counter wraps. Mid-draw width changes are reached by rewriting `size_sel` on a chosen pixel of an active draw, in both the growing and the shrinking direction. A strobe issued during blanking checks that the counter restart alone produces no image.

// File: rtl/sprpos_pkg.sv
package sprpos_pkg;

    typedef enum logic [1:0] {
        SCALE_X1 = 2'd0,
        SCALE_X2 = 2'd1,
        SCALE_X4 = 2'd2
    } scale_e;

    // Decoded view of the size/copies code
    typedef struct packed {
        logic   near_copy;   // extra copy at one gap
        logic   mid_copy;    // extra copy at two gaps
        logic   far_copy;    // extra copy at four gaps
        scale_e scale;
    } size_dec_t;

    function automatic size_dec_t decode_size(input logic [2:0] code);
        size_dec_t d;
        d = '{near_copy: 1'b0, mid_copy: 1'b0, far_copy: 1'b0, scale: SCALE_X1};
        case (code)
            3'd1: d.near_copy = 1'b1;
            3'd2: d.mid_copy  = 1'b1;
            3'd3: begin d.near_copy = 1'b1; d.mid_copy = 1'b1; end
            3'd4: d.far_copy  = 1'b1;
            3'd5: d.scale     = SCALE_X2;
            3'd6: begin d.mid_copy = 1'b1; d.far_copy = 1'b1; end
            3'd7: d.scale     = SCALE_X4;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sprpos_counter.sv
module sprpos_counter
    import sprpos_pkg::*;
#(
    parameter int LINE_PIX = 160,
    parameter int COPY_GAP = 16,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hblank,
    input  logic             pos_reset,
    input  logic [2:0]       size_code,
    output logic [CNT_W-1:0] cnt,
    output logic             start
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LINE_PIX - 1);
    localparam logic [CNT_W-1:0] OFS1 = CNT_W'(COPY_GAP);
    localparam logic [CNT_W-1:0] OFS2 = CNT_W'(2 * COPY_GAP);
    localparam logic [CNT_W-1:0] OFS4 = CNT_W'(4 * COPY_GAP);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    size_dec_t        dec;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        dec   = decode_size(size_code);
        st_d  = st_q;
        start = 1'b0;
        nxt   = (st_q.pos == LAST) ? '0 : st_q.pos + 1'b1;
        if (pos_reset) begin
            st_d.pos = '0;
            start    = !hblank;
        end else if (!hblank) begin
            st_d.pos = nxt;
            start    = (nxt == '0)
                     | (dec.near_copy && nxt == OFS1)
                     | (dec.mid_copy  && nxt == OFS2)
                     | (dec.far_copy  && nxt == OFS4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.pos;

endmodule

// File: rtl/sprpos_delay.sv
module sprpos_delay #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic start_in,
    output logic launch
);

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } dly_st_t;

    dly_st_t st_d, st_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                st_d.pipe = flush ? 1'b0 : start_in;
            end
        end else begin : g_chain
            always_comb begin
                st_d.pipe = flush ? '0 : {st_q.pipe[DEPTH-2:0], start_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign launch = st_q.pipe[DEPTH-1] & !flush;

endmodule

// File: rtl/sprpos_draw.sv
module sprpos_draw
    import sprpos_pkg::*;
#(
    parameter int BASE_W = 8,
    parameter int PIX_W  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hblank,
    input  logic       launch,
    input  logic [2:0] size_code,
    output logic       draw_en
);

    typedef struct packed {
        logic             active;
        logic [PIX_W-1:0] pix;
    } drw_st_t;

    drw_st_t          st_d, st_q;
    size_dec_t        dec;
    logic [PIX_W-1:0] width;
    logic [PIX_W-1:0] pix_inc;

    always_comb begin
        dec = decode_size(size_code);
        case (dec.scale)
            SCALE_X2: width = PIX_W'(2 * BASE_W);
            SCALE_X4: width = PIX_W'(4 * BASE_W);
            default:  width = PIX_W'(BASE_W);
        endcase
        pix_inc = st_q.pix + 1'b1;
        st_d    = st_q;
        if (hblank) begin
            st_d = '0;
        end else if (launch) begin
            st_d.active = 1'b1;
            st_d.pix    = '0;
        end else if (st_q.active) begin
            if (pix_inc >= width) st_d = '0;
            else                  st_d.pix = pix_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign draw_en = st_q.active & !hblank;

endmodule

// File: rtl/sprite_hpos.sv
module sprite_hpos #(
    parameter int LINE_PIX    = 160,
    parameter int COPY_GAP    = 16,
    parameter int BASE_W      = 8,
    parameter int START_DELAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hblank,
    input  logic       pos_reset,
    input  logic [2:0] size_sel,
    output logic       draw_en
);

    localparam int CNT_W     = $clog2(LINE_PIX);
    localparam int PIX_W     = $clog2(4 * BASE_W + 1);
    localparam int DLY_DEPTH = START_DELAY - 1;

    logic [CNT_W-1:0] cnt_w;
    logic             start_w;
    logic             launch_w;

    sprpos_counter #(
        .LINE_PIX (LINE_PIX),
        .COPY_GAP (COPY_GAP),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hblank    (hblank),
        .pos_reset (pos_reset),
        .size_code (size_sel),
        .cnt       (cnt_w),
        .start     (start_w)
    );

    sprpos_delay #(
        .DEPTH (DLY_DEPTH)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (hblank),
        .start_in (start_w),
        .launch   (launch_w)
    );

    sprpos_draw #(
        .BASE_W (BASE_W),
        .PIX_W  (PIX_W)
    ) u_drw (
        .clk       (clk),
        .rst_n     (rst_n),
        .hblank    (hblank),
        .launch    (launch_w),
        .size_code (size_sel),
        .draw_en   (draw_en)
    );

endmodule

// File: rtl/sprite_hpos_chk.sv
module sprite_hpos_chk #(
    parameter int BASE_W = 8,
    parameter int CNT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hblank,
    input logic             pos_reset,
    input logic             draw_en,
    input logic [CNT_W-1:0] cnt,
    input logic             start,
    input logic             launch
);

    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (launch)  run_q <= '0;
        else if (draw_en && run_q != 8'hff) run_q <= run_q + 1'b1;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && !pos_reset) |=> $stable(cnt));

    // R8
    strobe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_reset |=> (cnt == '0));

    // R3
    strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_reset && !hblank) |-> start);

    // R3
    draw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(draw_en) |-> $past(launch));

    // R7
    blank_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hblank |=> !launch);

    // R4
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        draw_en |-> (run_q < 8'(4 * BASE_W)));

endmodule

bind sprite_hpos sprite_hpos_chk #(
    .BASE_W (BASE_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hblank    (hblank),
    .pos_reset (pos_reset),
    .draw_en   (draw_en),
    .cnt       (cnt_w),
    .start     (start_w),
    .launch    (launch_w)
);

// File: tb/sprite_hpos_tb_top.sv
module sprite_hpos_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hblank;
    logic       pos_reset;
    logic [2:0] size_sel;
    logic       dp, dm;
    logic       sp, sm;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #2 clk = ~clk;

    sprite_hpos #(.BASE_W(8), .START_DELAY(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .pos_reset(pos_reset),
        .size_sel(size_sel), .draw_en(dp));

    sprite_hpos #(.BASE_W(1), .START_DELAY(2)) dut_m (
        .clk(clk), .rst_n(rst_n), .hblank(hblank), .pos_reset(pos_reset),
        .size_sel(size_sel), .draw_en(dm));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive inputs after the falling edge, sample shortly after
    task automatic cyc(input logic hb, input logic rs, input logic [2:0] sz);
        @(negedge clk);
        hblank = hb; pos_reset = rs; size_sel = sz;
        #1;
        sp = dp; sm = dm;
    endtask

    task automatic flush(input logic [2:0] sz);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, sz);
    endtask

    function automatic bit in_win(input int r, input int o, input int w);
        return (r >= o) && (r < o + w);
    endfunction

    // Expected draw state k visible clocks after a strobe, from R2..R5
    function automatic bit exp_on(input int k, input int dly, input int base, input logic [2:0] code);
        int r, w;
        bit on;
        r = ((k - dly) % 160 + 160) % 160;
        w = base * ((code == 3'd5) ? 2 : (code == 3'd7) ? 4 : 1);
        on = in_win(r, 0, w);
        if (code == 3'd1 || code == 3'd3) on |= in_win(r, 16, w);
        if (code == 3'd2 || code == 3'd3 || code == 3'd6) on |= in_win(r, 32, w);
        if (code == 3'd4 || code == 3'd6) on |= in_win(r, 64, w);
        return on;
    endfunction

    task automatic t_reset;
        int bad;
        bad = 0;
        rst_n = 1'b0; hblank = 1'b1; pos_reset = 1'b0; size_sel = 3'd0;
        repeat (3) @(negedge clk);
        #1;
        check(dp == 1'b0 && dm == 1'b0, "R1 in reset", {dp, dm}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc(1'b0, 1'b0, 3'd0);
            if (sp || sm) bad++;
        end
        check(bad == 0, "R1 idle after reset", bad, 0);
    endtask

    task automatic t_first_pixel;
        int fp, fm;
        fp = -1; fm = -1;
        flush(3'd0);
        for (int k = 0; k < 20; k++) begin
            cyc(1'b0, k == 0, 3'd0);
            if (sp && fp < 0) fp = k;
            if (sm && fm < 0) fm = k;
        end
        check(fp == 3, "R3 player first pixel", fp, 3);
        check(fm == 2, "R3 missile first pixel", fm, 2);
    endtask

    task automatic t_all_sizes;
        for (int c = 0; c < 8; c++) begin
            int bp, bm;
            bp = 0; bm = 0;
            flush(3'(c));
            for (int k = 0; k < 200; k++) begin
                cyc(1'b0, k == 0, 3'(c));
                if (sp != exp_on(k, 3, 8, 3'(c))) bp++;
                if (sm != exp_on(k, 2, 1, 3'(c))) bm++;
            end
            if (c == 0) begin
                check(bp == 0, "R2 player period", bp, 0);
                check(bm == 0, "R2 missile period", bm, 0);
            end else if (c == 5 || c == 7) begin
                check(bp == 0, "R4 player width", bp, 0);
                check(bm == 0, "R4 missile width", bm, 0);
            end else begin
                check(bp == 0, "R5 player copies", bp, 0);
                check(bm == 0, "R5 missile copies", bm, 0);
            end
        end
    endtask

    task automatic t_mid_grow;
        int bp, bm;
        bp = 0; bm = 0;
        flush(3'd0);
        for (int k = 0; k < 45; k++) begin
            cyc(1'b0, k == 0, (k >= 2) ? 3'd7 : 3'd0);
            if (sp != (k >= 3 && k <= 34)) bp++;
            if (sm != (k >= 2 && k <= 5)) bm++;
        end
        check(bp == 0, "R6 player grows mid-draw", bp, 0);
        check(bm == 0, "R6 missile grows mid-draw", bm, 0);
    endtask

    task automatic t_mid_shrink;
        int bp;
        bp = 0;
        flush(3'd7);
        for (int k = 0; k < 45; k++) begin
            cyc(1'b0, k == 0, (k >= 14) ? 3'd0 : 3'd7);
            if (sp != (k >= 3 && k <= 14)) bp++;
        end
        check(bp == 0, "R6 player shrinks mid-draw", bp, 0);
    endtask

    task automatic t_late_reset;
        int bp, bm, bb;
        bp = 0; bm = 0; bb = 0;
        flush(3'd0);
        cyc(1'b0, 1'b1, 3'd0);
        cyc(1'b0, 1'b0, 3'd0);
        for (int i = 0; i < 68; i++) begin
            cyc(1'b1, 1'b0, 3'd0);
            if (sp || sm) bb++;
        end
        check(bb == 0, "R7 dark during blank", bb, 0);
        for (int j = 0; j < 171; j++) begin
            cyc(1'b0, 1'b0, 3'd0);
            if (sp != (j >= 161 && j <= 168)) bp++;
            if (sm != (j == 160)) bm++;
        end
        check(bp == 0, "R7 player pending start dropped", bp, 0);
        check(bm == 0, "R7 missile pending start dropped", bm, 0);
    endtask

    task automatic t_wrap_cut;
        int bp, bm;
        bp = 0; bm = 0;
        flush(3'd0);
        for (int k = 0; k < 6; k++) cyc(1'b0, k == 0, 3'd0);
        check(sp == 1'b1, "R7 player drawing before cut", sp, 1);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 3'd0);
        for (int j = 0; j < 171; j++) begin
            cyc(1'b0, 1'b0, 3'd0);
            if (sp != (j >= 157 && j <= 164)) bp++;
            if (sm != (j == 156)) bm++;
        end
        check(bp == 0, "R7 player cut copy not resumed", bp, 0);
        check(bm == 0, "R7 missile after cut line", bm, 0);
    endtask

    task automatic t_reset_in_blank;
        int bp, bm;
        bp = 0; bm = 0;
        flush(3'd0);
        cyc(1'b1, 1'b1, 3'd0);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 3'd0);
        for (int j = 0; j < 171; j++) begin
            cyc(1'b0, 1'b0, 3'd0);
            if (sp != (j >= 162 && j <= 169)) bp++;
            if (sm != (j == 161)) bm++;
        end
        check(bp == 0, "R8 player strobe in blank", bp, 0);
        check(bm == 0, "R8 missile strobe in blank", bm, 0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_pixel();
        t_all_sizes();
        t_mid_grow();
        t_mid_shrink();
        t_late_reset();
        t_wrap_cut();
        t_reset_in_blank();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule